// File: doc/BRIEF.md
# Pulsed Self-Duality Signal Checker

This block watches one or more signals produced by a self-dual circuit that runs in pulsed mode. Each input vector is applied twice: first as is (the data cycle), then bitwise inverted (the check cycle). On a fault-free path, every monitored bit must flip between those two cycles. For every lane, the checker stores the data-cycle value and pairs it with the check-cycle value. It then presents the two as a parallel two-rail pair. A complementary pair gives 01 or 10. A pair that did not flip gives 00 or 11.

A plain level input tells the block whether the current cycle is a data or a check cycle. The block only honours a check cycle when it directly follows a cycle that was treated as data. A check flag at any other time is treated as a new data cycle. This keeps the pairing correct after reset and after a missed data pulse.

The results are registered, and a one-cycle strobe marks each completed pair. Between strobes, every lane rests on the valid code 01, so a two-rail compressor further down never sees a false error.

Samples are taken every clock. There is no back-pressure in either direction: the input side has no ready, and the strobe is a pure qualifier that the consumer must take in the cycle it is high.

Top module: `sd_pulse_checker`

## Requirements
- R1: While reset is high and in the first cycle after it, every lane shows z0=0, z1=1, and pair_vld is 0.
- R2: A cycle taken as data (chk_phase=0) stores each lane's mon bit. In the following cycle pair_vld=0 and every lane shows z0=0, z1=1.
- R3: A check cycle (chk_phase=1, directly after a cycle taken as data) in which a lane's mon bit is the inverse of its stored bit yields, in the next cycle, z0 = stored bit and z1 = current bit, so the lane shows 01 or 10.
- R4: A check cycle in which a lane's mon bit equals its stored bit yields, in the next cycle, 00 (both bits 0) or 11 (both bits 1) on that lane.
- R5: pair_vld is 1 in exactly the cycle after an honoured check cycle and 0 in every other cycle, so it is never high in two successive cycles.
- R6: A check flag on the first cycle after reset, or right after an honoured check cycle, is treated as a data cycle. pair_vld stays 0, the outputs stay 01, and the mon bit is stored for the next check.
- R7: Lanes are independent. A flip on one lane and no flip on another in the same check cycle give a two-rail code on the first lane and a non-two-rail code on the second.
- R8: Reset between a data cycle and its check cycle drops the stored pairing. The next check flag is treated as data per R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_phase | input | 1 | 0 = data cycle, 1 = check cycle |
| mon | input | LANES | Monitored bits, one per lane |
| z0 | output | LANES | First rail per lane (stored data-cycle bit) |
| z1 | output | LANES | Second rail per lane (check-cycle bit) |
| pair_vld | output | 1 | High for one cycle when z0/z1 hold a finished pair |

## Verification
The bench runs three lanes through all eight data patterns.

- Each pattern is paired once with its full complement, which must give a two-rail code on every lane.
- Each pattern is also paired with a version where one lane keeps its value. That lane alone must go to 00 or 11, which separates a lane-local compare from a shared one.

Check flags are also sent without a preceding data cycle: straight after reset, twice in a row, and after a reset placed inside a pair. These show whether the block tracks the phase itself or blindly trusts the flag.

// File: rtl/sd_pulse_pkg.sv
package sd_pulse_pkg;
  typedef enum logic {
    CYC_DATA  = 1'b0,
    CYC_CHECK = 1'b1
  } cyc_e;
endpackage

// File: rtl/sd_phase_track.sv
module sd_phase_track
  import sd_pulse_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic chk_phase,
  output cyc_e cyc
);
  logic armed_q;

  // A check flag is honoured only when the previous cycle was taken as data.
  always_comb begin
    cyc = (chk_phase && armed_q) ? CYC_CHECK : CYC_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= (cyc == CYC_DATA);
  end

  // R6
  no_double_check_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_CHECK) |=> (cyc == CYC_DATA));

  // R8
  no_check_after_reset_chk: assert property (@(posedge clk)
    rst |=> (cyc == CYC_DATA));
endmodule

// File: rtl/sd_lane.sv
module sd_lane
  import sd_pulse_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cyc_e cyc,
  input  logic mon,
  output logic z0,
  output logic z1
);
  logic held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      z0     <= 1'b0;
      z1     <= 1'b1;
    end else if (cyc == CYC_CHECK) begin
      z0 <= held_q;
      z1 <= mon;
    end else begin
      held_q <= mon;
      z0     <= 1'b0;
      z1     <= 1'b1;
    end
  end

  // R2
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_DATA) |=> (!z0 && z1));

  // R3
  flip_tworail_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_CHECK && mon != held_q) |=> (z0 != z1));

  // R4
  stuck_error_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_CHECK && mon == held_q) |=> (z0 == z1));
endmodule

// File: rtl/sd_pulse_checker.sv
module sd_pulse_checker
  import sd_pulse_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_phase,
  input  logic [LANES-1:0] mon,
  output logic [LANES-1:0] z0,
  output logic [LANES-1:0] z1,
  output logic             pair_vld
);
  cyc_e cyc;

  sd_phase_track u_phase (
    .clk       (clk),
    .rst       (rst),
    .chk_phase (chk_phase),
    .cyc       (cyc)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sd_lane u_lane (
      .clk (clk),
      .rst (rst),
      .cyc (cyc),
      .mon (mon[g]),
      .z0  (z0[g]),
      .z1  (z1[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pair_vld <= 1'b0;
    else     pair_vld <= (cyc == CYC_CHECK);
  end

  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    pair_vld |=> !pair_vld);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!pair_vld && z0 == '0 && z1 == '1));
endmodule

// File: tb/tb_sd_pulse_checker.sv
module tb_sd_pulse_checker;
  localparam int L = 3;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         chk_phase = 1'b0;
  logic [L-1:0] mon = '0;
  logic [L-1:0] z0, z1;
  logic         pair_vld;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  sd_pulse_checker #(.LANES(L)) dut (
    .clk(clk), .rst(rst), .chk_phase(chk_phase), .mon(mon),
    .z0(z0), .z1(z1), .pair_vld(pair_vld)
  );

  task automatic check(string req, logic [2*L:0] act, logic [2*L:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got vld/z0/z1=%b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle, then sample the registered outputs just after the edge.
  task automatic cycle(input logic c, input logic [L-1:0] m);
    @(negedge clk);
    chk_phase = c;
    mon = m;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [2*L:0] idle_v();
    return {1'b0, {L{1'b0}}, {L{1'b1}}};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    cycle(1'b0, '1);
    check("R1 in reset", {pair_vld, z0, z1}, idle_v());
    cycle(1'b1, '1);
    rst = 1'b0;
    cycle(1'b0, 3'b101);
    check("R1 after reset", {pair_vld, z0, z1}, idle_v());
  endtask

  task automatic t_pairs();
    for (int d = 0; d < 8; d++) begin
      cycle(1'b0, 3'(d));
      check("R2 data cycle", {pair_vld, z0, z1}, idle_v());
      cycle(1'b1, ~3'(d));
      check("R3 complement pair", {pair_vld, z0, z1}, {1'b1, 3'(d), ~3'(d)});
      for (int k = 0; k < L; k++) begin
        logic [L-1:0] c;
        c = ~3'(d);
        c[k] = d[k];
        cycle(1'b0, 3'(d));
        cycle(1'b1, c);
        check("R4 R7 one lane stuck", {pair_vld, z0, z1}, {1'b1, 3'(d), c});
        check("R4 stuck lane equal", {2'b00, z0[k] ^ z1[k]}, 3'b000);
      end
    end
  endtask

  task automatic t_unpaired();
    // Check flag straight after reset.
    rst = 1'b1;
    cycle(1'b0, '0);
    rst = 1'b0;
    cycle(1'b1, 3'b110);
    check("R6 check after reset", {pair_vld, z0, z1}, idle_v());
    cycle(1'b1, 3'b001);
    check("R6 stored by ignored flag", {pair_vld, z0, z1}, {1'b1, 3'b110, 3'b001});
    cycle(1'b1, 3'b011);
    check("R5 R6 second check taken as data", {pair_vld, z0, z1}, idle_v());
    cycle(1'b1, 3'b011);
    check("R4 pair after double flag", {pair_vld, z0, z1}, {1'b1, 3'b011, 3'b011});
    cycle(1'b0, 3'b111);
    check("R5 strobe drops", {pair_vld, z0, z1}, idle_v());
    // Reset in the middle of a pair.
    rst = 1'b1;
    cycle(1'b0, '0);
    rst = 1'b0;
    cycle(1'b1, 3'b010);
    check("R8 check after mid-pair reset", {pair_vld, z0, z1}, idle_v());
    cycle(1'b1, 3'b101);
    check("R8 new pairing", {pair_vld, z0, z1}, {1'b1, 3'b010, 3'b101});
  endtask

  initial begin
    t_reset();
    t_pairs();
    t_unpaired();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule